// File: doc/BRIEF.md
# Single-Wire Bus Device Selection and Identity Search

This block is the selection layer of a slave on a multi-drop single-wire bus. It sits between the slot layer, which turns bus waveforms into write-slot, read-slot and bus-reset events, and the memory command engine. After every bus reset it collects one ROM-level command byte. Depending on that byte it sends its 64-bit identity, compares the host's 64 bits against that identity, selects itself at once, or takes part in a bitwise identity search. When the sequence succeeds it raises `selected`, and the memory layer takes the following slots.

The identity has three parts, each sent least significant bit first: the family code, a 48-bit serial number taken from a fuse-style input, and an 8-bit check value. The check value is not stored. It is built bit by bit in hardware from the first 56 identity bits as they go past. In a search, every identity bit costs three slots: the device sends the bit, then sends its complement, then reads the bit the host echoes. If the echoed bit differs, the device releases the bus until the next bus reset. When several devices answer together, the wired-AND bus can return 0 in both read slots, and the host sees this as a collision.

Top module: `rom_select`

## Requirements
- R1: The identity is sent in this order: family code bits 0..7 (default 09h), then serial bits 0..47, then check bits 0..7. Each field goes least significant bit first, and one bit is given per read slot.
- R2: The check byte is the reflected CRC-8 with polynomial x^8+x^5+x^4+1 (shift-right form, constant 8Ch, initial value 00h) over the 56 family and serial bits. Check bit k is sent in identity position 56+k.
- R3: Opcode 33h (received LSB first over eight write slots) makes the device answer the next 64 read slots with its identity. After the 64th read slot `selected` is 1.
- R4: Opcode 55h makes the device take 64 write slots and compare each bit with the identity bit at that position. `selected` becomes 1 after the 64th bit only if all 64 bits match.
- R5: A mismatching bit during opcode 55h leaves `selected` at 0 from then on. `rd_bit` stays 1 (bus released) until the next bus reset.
- R6: Opcode CCh sets `selected` to 1 right after the eighth command slot, with no identity exchange.
- R7: Opcode F0h starts a search. For each identity bit, the first read slot returns the bit, the second returns its complement, and a write slot then takes the host's bit. After 64 matching rounds `selected` is 1.
- R8: In a search, a host bit that differs from the device's bit makes the device silent: `rd_bit` is 1 and `selected` is 0 until the next bus reset.
- R9: Any other opcode leaves the device silent and deselected until the next bus reset.
- R10: A bus reset at any point clears `selected` and starts a new command byte. The next identity exchange starts again at bit 0.
- R11: While selected, `selected` stays 1 until a bus reset, and `rd_bit` is 1 so that the memory layer owns the bus.
- R12: `rd_bit` and `selected` change only in the cycle after a slot event or a bus reset. After the power-on reset, `selected` is 0, `rd_bit` is 1, and the device waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_no | input | SER_W | Factory serial number, identity bits 8..55 |
| bus_rst | input | 1 | One-cycle pulse: bus reset detected by the slot layer |
| slot_wr | input | 1 | One-cycle pulse: the host completed a write slot |
| slot_wr_bit | input | 1 | Value of the write slot reported with `slot_wr` |
| slot_rd | input | 1 | One-cycle pulse: the host completed a read slot |
| rd_bit | output | 1 | Level for the next read slot: 0 pulls the bus low, 1 releases it |
| selected | output | 1 | Device selected; memory-level commands may follow |

## Verification
The bench builds the block with the default family code 09h and a 48-bit serial, and feeds a serial with a dense mix of ones and zeros, so that the CRC register goes through many feedback steps before its byte is sent. Because the family width is 8 and the serial width is 48, the index hits both field boundaries and the move from body bits to check bits at bit 56. A mismatch is placed inside the check byte, so it reaches the computed part of the identity. A search drop is placed at an early bit, so that silence can be seen across the remaining rounds.

// File: rtl/rom_sel_pkg.sv
package rom_sel_pkg;

  typedef enum logic [2:0] {
    S_CMD,
    S_READ,
    S_MATCH,
    S_SRCH_T,
    S_SRCH_C,
    S_SRCH_H,
    S_SEL,
    S_QUIET
  } rom_state_e;

  localparam logic [7:0] OP_READ  = 8'h33;
  localparam logic [7:0] OP_MATCH = 8'h55;
  localparam logic [7:0] OP_SKIP  = 8'hCC;
  localparam logic [7:0] OP_SRCH  = 8'hF0;

endpackage

// File: rtl/rom_op_rx.sv
module rom_op_rx #(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic            bit_in,
  output logic            done,
  output logic [OP_W-1:0] op_full
);
  localparam int CNT_W = $clog2(OP_W);

  logic [OP_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign op_full = {bit_in, sh_q[OP_W-1:1]};
  assign done    = en && (cnt_q == CNT_W'(OP_W-1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      sh_d  = op_full;
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rom_id_seq.sv
module rom_id_seq #(
  parameter int         BODY_W = 56,
  parameter int         CRC_W  = 8,
  parameter logic [7:0] POLY   = 8'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [BODY_W-1:0] id_body,
  output logic              cur_bit,
  output logic              last
);
  localparam int ID_W  = BODY_W + CRC_W;
  localparam int IDX_W = $clog2(ID_W);
  localparam int CS_W  = $clog2(CRC_W);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [IDX_W-1:0] crc_off;
  logic             in_body;

  assign in_body = (idx_q < IDX_W'(BODY_W));
  assign crc_off = idx_q - IDX_W'(BODY_W);
  assign cur_bit = in_body ? id_body[idx_q] : crc_q[crc_off[CS_W-1:0]];
  assign last    = (idx_q == IDX_W'(ID_W-1));

  always_comb begin
    idx_d = idx_q;
    crc_d = crc_q;
    if (clr) begin
      idx_d = '0;
      crc_d = '0;
    end else if (adv) begin
      idx_d = last ? '0 : idx_q + 1'b1;
      if (in_body) begin
        crc_d = (crc_q >> 1) ^ ((crc_q[0] ^ cur_bit) ? POLY[CRC_W-1:0] : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      crc_q <= '0;
    end else begin
      idx_q <= idx_d;
      crc_q <= crc_d;
    end
  end
endmodule

// File: rtl/rom_select.sv
module rom_select
  import rom_sel_pkg::*;
#(
  parameter logic [7:0] FAMILY_CODE = 8'h09,
  parameter int         SER_W       = 48,
  parameter logic [7:0] CRC_POLY    = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SER_W-1:0] serial_no,
  input  logic             bus_rst,
  input  logic             slot_wr,
  input  logic             slot_wr_bit,
  input  logic             slot_rd,
  output logic             rd_bit,
  output logic             selected
);
  localparam int FAM_W  = 8;
  localparam int BODY_W = FAM_W + SER_W;

  rom_state_e       st_q, st_d;
  logic             op_en, op_done, adv, cur_bit, last;
  logic [7:0]       op_full;
  logic [BODY_W-1:0] id_body;

  assign id_body = {serial_no, FAMILY_CODE};

  rom_op_rx #(.OP_W(8)) u_op_rx (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .en(op_en),
    .bit_in(slot_wr_bit), .done(op_done), .op_full(op_full)
  );

  rom_id_seq #(.BODY_W(BODY_W), .CRC_W(8), .POLY(CRC_POLY)) u_id_seq (
    .clk(clk), .rst_n(rst_n), .clr(bus_rst), .adv(adv),
    .id_body(id_body), .cur_bit(cur_bit), .last(last)
  );

  always_comb begin
    st_d  = st_q;
    op_en = 1'b0;
    adv   = 1'b0;
    if (bus_rst) begin
      st_d = S_CMD;
    end else begin
      unique case (st_q)
        S_CMD: if (slot_wr) begin
          op_en = 1'b1;
          if (op_done) begin
            case (op_full)
              OP_READ:  st_d = S_READ;
              OP_MATCH: st_d = S_MATCH;
              OP_SKIP:  st_d = S_SEL;
              OP_SRCH:  st_d = S_SRCH_T;
              default:  st_d = S_QUIET;
            endcase
          end
        end
        S_READ: if (slot_rd) begin
          adv = 1'b1;
          if (last) st_d = S_SEL;
        end
        S_MATCH: if (slot_wr) begin
          if (slot_wr_bit != cur_bit) begin
            st_d = S_QUIET;
          end else begin
            adv = 1'b1;
            if (last) st_d = S_SEL;
          end
        end
        S_SRCH_T: if (slot_rd) st_d = S_SRCH_C;
        S_SRCH_C: if (slot_rd) st_d = S_SRCH_H;
        S_SRCH_H: if (slot_wr) begin
          if (slot_wr_bit != cur_bit) begin
            st_d = S_QUIET;
          end else begin
            adv  = 1'b1;
            st_d = last ? S_SEL : S_SRCH_T;
          end
        end
        S_SEL:   st_d = S_SEL;
        S_QUIET: st_d = S_QUIET;
        default: st_d = S_QUIET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_CMD;
    else        st_q <= st_d;
  end

  always_comb begin
    unique case (st_q)
      S_READ, S_SRCH_T: rd_bit = cur_bit;
      S_SRCH_C:         rd_bit = ~cur_bit;
      default:          rd_bit = 1'b1;
    endcase
  end

  assign selected = (st_q == S_SEL);
endmodule

// File: rtl/rom_select_chk.sv
module rom_select_chk
  import rom_sel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst,
  input logic       slot_wr,
  input logic       slot_rd,
  input logic       rd_bit,
  input logic       selected,
  input rom_state_e st_q
);
  a_r10_rst_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !selected);

  a_r11_sel_releases: assert property (@(posedge clk) disable iff (!rst_n)
    selected |-> rd_bit);

  a_r11_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !bus_rst) |=> selected);

  a_r12_no_event_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_rd && !slot_wr && !bus_rst) |=> ($stable(rd_bit) && $stable(selected)));

  a_r7_pair_complement: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_SRCH_C) && $past(st_q == S_SRCH_T)) |-> (rd_bit != $past(rd_bit)));

  a_r8_quiet_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_QUIET) |-> (rd_bit && !selected));
endmodule

bind rom_select rom_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .slot_wr(slot_wr),
  .slot_rd(slot_rd), .rd_bit(rd_bit), .selected(selected), .st_q(st_q)
);

// File: tb/rom_select_tb.sv
module rom_select_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, bus_rst, slot_wr, slot_wr_bit, slot_rd;
  logic        rd_bit, selected;
  logic [47:0] serial_no;
  logic [63:0] exp_id;
  int          n_chk, n_fail;
  bit          finished;

  rom_select u_dut (
    .clk(clk), .rst_n(rst_n), .serial_no(serial_no), .bus_rst(bus_rst),
    .slot_wr(slot_wr), .slot_wr_bit(slot_wr_bit), .slot_rd(slot_rd),
    .rd_bit(rd_bit), .selected(selected)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] crc_of(input logic [55:0] body);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      c = (c >> 1) ^ ((c[0] ^ body[i]) ? 8'h8C : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
  endtask

  task automatic wr_slot(input logic b);
    @(negedge clk); slot_wr = 1'b1; slot_wr_bit = b;
    @(negedge clk); slot_wr = 1'b0; slot_wr_bit = 1'b0;
  endtask

  task automatic rd_slot(output logic b);
    @(negedge clk); b = rd_bit; slot_rd = 1'b1;
    @(negedge clk); slot_rd = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_slot(v[i]);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(!selected && rd_bit, "R12 reset state", {62'd0, selected, rd_bit}, 64'd1);
  endtask

  task automatic t_read_rom();
    logic [63:0] got;
    logic        b;
    do_bus_rst(); wr_byte(8'h33);
    for (int i = 0; i < 64; i++) begin rd_slot(b); got[i] = b; end
    @(negedge clk);
    chk(got[55:0] == exp_id[55:0], "R1 identity body order", {8'd0, got[55:0]}, {8'd0, exp_id[55:0]});
    chk(got[63:56] == exp_id[63:56], "R2 check byte", {56'd0, got[63:56]}, {56'd0, exp_id[63:56]});
    chk(selected, "R3 selected after read", {63'd0, selected}, 64'd1);
    rd_slot(b);
    chk(b && selected, "R11 releases while selected", {62'd0, selected, b}, 64'd3);
  endtask

  task automatic t_match(input int bad);
    logic b;
    do_bus_rst(); wr_byte(8'h55);
    for (int i = 0; i < 64; i++) wr_slot(i == bad ? ~exp_id[i] : exp_id[i]);
    @(negedge clk);
    if (bad < 0) chk(selected, "R4 full match selects", {63'd0, selected}, 64'd1);
    else begin
      chk(!selected, "R5 mismatch deselects", {63'd0, selected}, 64'd0);
      rd_slot(b);
      chk(b, "R5 bus released after mismatch", {63'd0, b}, 64'd1);
    end
  endtask

  task automatic t_skip();
    do_bus_rst(); wr_byte(8'hCC);
    @(negedge clk);
    chk(selected, "R6 skip selects", {63'd0, selected}, 64'd1);
  endtask

  task automatic t_unknown();
    logic b, any0;
    do_bus_rst(); wr_byte(8'hA5);
    any0 = 1'b0;
    for (int i = 0; i < 8; i++) begin rd_slot(b); if (!b) any0 = 1'b1; end
    chk(!selected && !any0, "R9 unknown opcode silent", {62'd0, selected, any0}, 64'd0);
  endtask

  task automatic t_search(input int drop);
    logic b, c, pairs_ok, any0;
    do_bus_rst(); wr_byte(8'hF0);
    pairs_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i > drop && drop >= 0) break;
      rd_slot(b); rd_slot(c);
      if (b != exp_id[i] || c != ~exp_id[i]) pairs_ok = 1'b0;
      wr_slot(i == drop ? ~exp_id[i] : exp_id[i]);
    end
    chk(pairs_ok, "R7 true and complement pairs", {63'd0, pairs_ok}, 64'd1);
    @(negedge clk);
    if (drop < 0) chk(selected, "R7 search completes selected", {63'd0, selected}, 64'd1);
    else begin
      any0 = 1'b0;
      for (int i = 0; i < 12; i++) begin rd_slot(b); if (!b) any0 = 1'b1; end
      chk(!selected && !any0, "R8 dropped device silent", {62'd0, selected, any0}, 64'd0);
    end
  endtask

  task automatic t_rst_mid();
    logic [15:0] got;
    logic        b;
    do_bus_rst(); wr_byte(8'h33);
    for (int i = 0; i < 20; i++) rd_slot(b);
    do_bus_rst();
    @(negedge clk);
    chk(!selected && rd_bit, "R10 reset mid-read idle", {62'd0, selected, rd_bit}, 64'd1);
    wr_byte(8'h33);
    for (int i = 0; i < 16; i++) begin rd_slot(b); got[i] = b; end
    chk(got == exp_id[15:0], "R10 restart at bit 0", {48'd0, got}, {48'd0, exp_id[15:0]});
    t_skip();
    do_bus_rst(); @(negedge clk);
    chk(!selected, "R10 reset clears selection", {63'd0, selected}, 64'd0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 1'b0;
    serial_no = 48'hA5C3_96E1_7B2D;
    exp_id = {crc_of({serial_no, 8'h09}), serial_no, 8'h09};
    rst_n = 1'b0; bus_rst = 1'b0; slot_wr = 1'b0; slot_wr_bit = 1'b0; slot_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_read_rom();
    t_match(-1);
    t_match(60);
    t_match(3);
    t_skip();
    t_unknown();
    t_search(-1);
    t_search(5);
    t_rst_mid();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule